// File: doc/BRIEF.md
# Bus Address Decoder with Access Guard

This block sits on a shared system bus next to the arbiter. It looks at the address, transfer type, protection code and direction that the current master puts out in the address phase. For the data phase that follows, it asserts one select line for the addressed slave. Each slave region has a base and a mask, both fixed by parameters. A region matches when the masked address equals its base. Each region can also be marked supervisor-only, instruction-only, or both.

The block also acts as a simple protection unit. An access is refused in three cases: a user-mode access to a supervisor-only region, a write to an instruction-only region, or an access whose address matches no region. A refused access raises a one-cycle abort and selects no slave. Whenever no slave is selected, the block answers the bus itself with a zero wait response, so such a data phase ends at once. While a selected slave holds its wait line high, the block keeps its selection and does not sample a new address.

The protection code has two bits. Bit 0 set means a data access and clear means an opcode fetch. Bit 1 set means supervisor mode and clear means user mode. The transfer type is a two-bit code. A code of 2'b10 (nonsequential) or 2'b11 (sequential) moves data. A code of 2'b00 (address-only) or 2'b01 (reserved) moves none.

Top module: `bus_addr_guard`

## Requirements
- R1: When the bus is not stalled and a data-moving transfer (type 2'b10 or 2'b11) targets a mapped, permitted address, the next cycle asserts exactly one select bit: the one for the region where (addr & mask) == base. With the defaults these regions are 0x0xxxxxxx → bit 0, 0x1xxxxxxx → bit 1, 0x20xxxxxx → bit 2 and 0x3xxxxxxx → bit 3.
- R2: A transfer of type 2'b00 or 2'b01 gives, in the next cycle, no select, no abort and a low wait response, whatever its address.
- R3: While a select bit is asserted, the wait output equals the wait input of that slave. Wait inputs of slaves that are not selected have no effect. With no select asserted, the wait output is low.
- R4: While the wait output is high, the select lines hold their value, and the address-phase inputs are ignored until the cycle after wait goes low.
- R5: A user-mode access (protection bit 1 clear) to a supervisor-only region gives, in the next cycle, an abort and no select. With the defaults, regions 2 and 3 are supervisor-only.
- R6: A write to an instruction-only region is aborted with no select, in any mode. Reads and fetches of that region are allowed. With the defaults, region 0 is instruction-only.
- R7: A data-moving transfer to an address that matches no region gives, in the next cycle, an abort, no select and a low wait response.
- R8: During and directly after reset, all selects, the abort and the wait output are low.
- R9: A supervisor-mode access (protection bit 1 set) to a supervisor-only region is granted its select.
- R10: A write marked as an opcode fetch (protection bit 0 clear) is malformed and is aborted with no select, even to a mapped, unrestricted region.
- R11: An abort lasts a single cycle unless the next address phase is also refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Address of the active master |
| xfer | input | 2 | Transfer type code |
| prot | input | 2 | Protection code: bit 0 data/fetch, bit 1 supervisor/user |
| write | input | 1 | High for a write transfer |
| slave_wait | input | N_SLV | Wait response from each slave |
| sel | output | N_SLV | One-hot slave selects for the data phase |
| bus_wait | output | 1 | Combined wait response on the bus |
| abort | output | 1 | One-cycle abort for a refused or unmapped access |

## Verification
The registered selection is the only state. If it is wrong, the wrong slave select or a spurious abort shows on the ports in the cycle right after the address phase. The bench checks every decision exactly one clock after it drives the address. A selection that wrongly follows the address during a stall shows up as a changed select while wait is still high. A selection that wrongly stays set would keep routing a slave's wait onto the bus, so the stall tests look at both wait and select on every cycle of the release.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    typedef enum logic [1:0] {
        XF_ADDR_ONLY = 2'b00,
        XF_RESERVED  = 2'b01,
        XF_NONSEQ    = 2'b10,
        XF_SEQ       = 2'b11
    } xfer_e;

    localparam int PROT_DATA_BIT = 0;
    localparam int PROT_SUPV_BIT = 1;

    // Only the nonsequential and sequential codes carry a data phase.
    function automatic logic xfer_moves_data(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int ADDR_W = 32,
    parameter int N_REG  = 4,
    parameter logic [N_REG*ADDR_W-1:0] BASE = '0,
    parameter logic [N_REG*ADDR_W-1:0] MASK = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REG-1:0]  hit_oh,
    output logic              mapped
);

    logic [N_REG-1:0] raw_hit;

    for (genvar g = 0; g < N_REG; g++) begin : g_cmp
        assign raw_hit[g] = ((addr & MASK[g*ADDR_W +: ADDR_W]) == BASE[g*ADDR_W +: ADDR_W]);
    end

    // Overlapping regions resolve to the lowest index.
    always_comb begin
        logic taken;
        taken  = 1'b0;
        hit_oh = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (raw_hit[i] && !taken) begin
                hit_oh[i] = 1'b1;
                taken     = 1'b1;
            end
        end
    end

    assign mapped = |raw_hit;

    always_comb begin
        AST_HIT_ONEHOT: assert ($onehot0(hit_oh)); // R1
        AST_HIT_MAPPED: assert (mapped == (hit_oh != '0)); // R7
    end

endmodule

// File: rtl/access_guard.sv
module access_guard
    import addr_guard_pkg::*;
#(
    parameter int N_REG = 4,
    parameter logic [N_REG-1:0] PRIV  = '0,
    parameter logic [N_REG-1:0] XONLY = '0
) (
    input  logic [N_REG-1:0] hit_oh,
    input  logic [1:0]       prot,
    input  logic             write,
    output logic             deny
);

    logic user_into_priv;
    logic write_into_xonly;
    logic fetch_write;

    assign user_into_priv   = !prot[PROT_SUPV_BIT] && ((hit_oh & PRIV) != '0);
    assign write_into_xonly = write && ((hit_oh & XONLY) != '0);
    assign fetch_write      = write && !prot[PROT_DATA_BIT];
    assign deny             = user_into_priv || write_into_xonly || fetch_write;

    always_comb begin
        AST_DENY_HAS_CAUSE: assert (!deny || write || !prot[PROT_SUPV_BIT]); // R5
    end

endmodule

// File: rtl/bus_addr_guard.sv
module bus_addr_guard
    import addr_guard_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_SLV  = 4,
    parameter logic [N_SLV*ADDR_W-1:0] REGION_BASE =
        {32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
    parameter logic [N_SLV*ADDR_W-1:0] REGION_MASK =
        {32'hF000_0000, 32'hFF00_0000, 32'hF000_0000, 32'hF000_0000},
    parameter logic [N_SLV-1:0] REGION_PRIV  = 4'b1100,
    parameter logic [N_SLV-1:0] REGION_XONLY = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        xfer,
    input  logic [1:0]        prot,
    input  logic              write,
    input  logic [N_SLV-1:0]  slave_wait,
    output logic [N_SLV-1:0]  sel,
    output logic              bus_wait,
    output logic              abort
);

    typedef struct packed {
        logic [N_SLV-1:0] sel;
        logic             abort;
    } phase_t;

    phase_t           st_d, st_q;
    logic [N_SLV-1:0] hit_oh;
    logic             mapped;
    logic             deny;
    logic             moves;

    region_match #(
        .ADDR_W (ADDR_W),
        .N_REG  (N_SLV),
        .BASE   (REGION_BASE),
        .MASK   (REGION_MASK)
    ) u_match (
        .addr   (addr),
        .hit_oh (hit_oh),
        .mapped (mapped)
    );

    access_guard #(
        .N_REG (N_SLV),
        .PRIV  (REGION_PRIV),
        .XONLY (REGION_XONLY)
    ) u_guard (
        .hit_oh (hit_oh),
        .prot   (prot),
        .write  (write),
        .deny   (deny)
    );

    assign moves    = xfer_moves_data(xfer);
    assign bus_wait = |(st_q.sel & slave_wait);

    always_comb begin
        st_d = st_q;
        if (!bus_wait) begin
            st_d.sel   = '0;
            st_d.abort = 1'b0;
            if (moves) begin
                if (!mapped || deny) begin
                    st_d.abort = 1'b1;
                end else begin
                    st_d.sel = hit_oh;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel   = st_q.sel;
    assign abort = st_q.abort;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R1
    AST_ABORT_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (sel == '0 && !bus_wait)); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |=> $stable(sel)); // R4
    AST_ADDR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wait && !xfer[1]) |=> (sel == '0 && !abort)); // R2
    AST_USER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wait && moves && !prot[PROT_SUPV_BIT] && ((hit_oh & REGION_PRIV) != '0))
        |=> (abort && sel == '0)); // R5

endmodule

// File: tb/tb_bus_addr_guard.sv
module tb_bus_addr_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  xfer = 2'b00;
    logic [1:0]  prot = 2'b00;
    logic        write = 1'b0;
    logic [3:0]  slave_wait = '0;
    logic [3:0]  sel;
    logic        bus_wait;
    logic        abort;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_addr_guard dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .xfer(xfer), .prot(prot),
        .write(write), .slave_wait(slave_wait),
        .sel(sel), .bus_wait(bus_wait), .abort(abort)
    );

    task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s {sel,wait,abort} got %b expected %b", req, got, exp);
        end
    endtask

    // Drive one address phase at a falling edge and check the data phase one falling edge later.
    task automatic phase(input string req, input logic [31:0] a, input logic [1:0] t,
                         input logic [1:0] p, input logic w,
                         input logic [3:0] exp_sel, input logic exp_abort);
        @(negedge clk);
        addr = a; xfer = t; prot = p; write = w;
        @(negedge clk);
        chk(req, {sel, bus_wait, abort}, {exp_sel, 1'b0, exp_abort});
    endtask

    task automatic t_reset();
        chk("R8 in reset", {sel, bus_wait, abort}, 6'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset", {sel, bus_wait, abort}, 6'b0);
    endtask

    task automatic t_grants();
        phase("R1 fetch r0",        32'h0000_0100, 2'b10, 2'b00, 1'b0, 4'b0001, 1'b0);
        phase("R1 user write r1",   32'h1000_0040, 2'b11, 2'b01, 1'b1, 4'b0010, 1'b0);
        phase("R9 supv read r2",    32'h2000_0010, 2'b10, 2'b11, 1'b0, 4'b0100, 1'b0);
        phase("R9 supv write r3",   32'h3FFF_FFFC, 2'b11, 2'b11, 1'b1, 4'b1000, 1'b0);
        phase("R6 user read r0",    32'h0ABC_0000, 2'b10, 2'b01, 1'b0, 4'b0001, 1'b0);
    endtask

    task automatic t_addr_only();
        phase("R2 type 00",         32'h1000_0000, 2'b00, 2'b11, 1'b0, 4'b0000, 1'b0);
        phase("R2 type 01",         32'h8000_0000, 2'b01, 2'b00, 1'b1, 4'b0000, 1'b0);
    endtask

    task automatic t_refusals();
        phase("R5 user read r2",    32'h2000_0000, 2'b10, 2'b01, 1'b0, 4'b0000, 1'b1);
        phase("R11 abort clears",   32'h2000_0000, 2'b00, 2'b01, 1'b0, 4'b0000, 1'b0);
        phase("R5 user fetch r3",   32'h3000_1000, 2'b11, 2'b00, 1'b0, 4'b0000, 1'b1);
        phase("R6 supv write r0",   32'h0000_0200, 2'b10, 2'b11, 1'b1, 4'b0000, 1'b1);
        phase("R7 hole above r2",   32'h2100_0000, 2'b10, 2'b11, 1'b0, 4'b0000, 1'b1);
        phase("R7 high unmapped",   32'h8000_0000, 2'b11, 2'b11, 1'b0, 4'b0000, 1'b1);
        phase("R10 fetch write r1", 32'h1000_0000, 2'b10, 2'b10, 1'b1, 4'b0000, 1'b1);
        phase("R11 grant after",    32'h1000_0004, 2'b10, 2'b11, 1'b0, 4'b0010, 1'b0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        slave_wait = 4'b1101;
        addr = 32'h1000_0000; xfer = 2'b10; prot = 2'b11; write = 1'b0;
        @(negedge clk);
        chk("R3 other waits ignored", {sel, bus_wait, abort}, {4'b0010, 1'b0, 1'b0});
        slave_wait = 4'b0010;
        #1;
        chk("R3 selected wait passes", {sel, bus_wait, abort}, {4'b0010, 1'b1, 1'b0});
        addr = 32'h3000_0000; xfer = 2'b10; prot = 2'b11;
        @(negedge clk);
        chk("R4 hold during stall", {sel, bus_wait, abort}, {4'b0010, 1'b1, 1'b0});
        addr = 32'h8000_0000;
        @(negedge clk);
        chk("R4 unmapped ignored in stall", {sel, bus_wait, abort}, {4'b0010, 1'b1, 1'b0});
        addr = 32'h3000_0000;
        slave_wait = 4'b0000;
        #1;
        chk("R3 wait released", {sel, bus_wait, abort}, {4'b0010, 1'b0, 1'b0});
        @(negedge clk);
        chk("R4 new address after stall", {sel, bus_wait, abort}, {4'b1000, 1'b0, 1'b0});
        xfer = 2'b00;
        @(negedge clk);
        chk("R3 idle wait low", {sel, bus_wait, abort}, 6'b0);
    endtask

    initial begin
        #2;
        t_reset();
        t_grants();
        t_addr_only();
        t_refusals();
        t_stall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule